// File: doc/BRIEF.md
# Dual-Mode Serial Shift Engine

This block is the serial port of a small 8-bit processor. It is a mode-0 serial master. It carries out one-byte writes and one-byte reads for the processor. It also receives 12-bit setup packets from a loader, each an 8-bit payload with a 4-bit address above it. One request starts one transfer. While the transfer runs, `busy` holds the processor's program counter. The shift register is visible in parallel on `buffer`, so the processor can read the received byte from its low eight bits. In loader mode the whole packet is on `buffer`.

The serial clock is the system clock inverted, and it runs only while a transfer is active. The shift register, the bit counter and the chip-select register all change on the falling edge of the system clock. That edge is the rising edge of the serial clock, where both ends sample data.

In a normal read, miso passes through a one-bit staging register on its way to the shift register. A final flush edge empties that stage into the shift register. In loader mode the incoming bits enter the shift register directly from miso.

Top module: `spi_shift_engine`

## Requirements
- R1: While reset is applied, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `buffer` is 0.
- R2: A request seen on a rising clock edge while idle starts a transfer. `busy` is 1 from that edge for exactly 9 cycles for a write, 10 for a normal read and 13 for a loader packet.
- R3: When `init_mode` is 1, either request starts a 12-bit loader receive. Otherwise `read_req` takes priority over `send_req`.
- R4: The bit counter reloads to 8 for normal transfers and to 12 in loader mode. `cs_n` is 0 for exactly that many cycles, starting on the falling edge after the accepting edge, and `sclk` has exactly that many rising edges.
- R5: `sclk` is the inverted system clock while a transfer runs and stays at 0 whenever `cs_n` has been 1 for two edges.
- R6: In a write, `mosi` presents `wr_data` least-significant bit first, one new bit per rising edge of `sclk`. `mosi` is 0 whenever `cs_n` is 1 or the transfer is not a write.
- R7: In a normal read, the eight bits sampled at the eight `sclk` rising edges end up in `buffer[7:0]`, the first bit in bit 0. `buffer[11:8]` is left unchanged.
- R8: In loader mode, the twelve sampled bits fill `buffer[11:0]`, the first bit in bit 0. The payload is in `buffer[7:0]` and the address in `buffer[11:8]`.
- R9: A write leaves `buffer[7:0]` at 0 and `buffer[11:8]` unchanged.
- R10: While `busy` is 1, requests are ignored. A change of `wr_data` or `init_mode` during that time has no effect on the transfer, its length or its result.
- R11: Between transfers, `buffer` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| send_req | input | 1 | Request for a one-byte write |
| read_req | input | 1 | Request for a one-byte read |
| init_mode | input | 1 | Selects a 12-bit loader receive |
| wr_data | input | 8 | Byte to send, sampled when the request is accepted |
| miso | input | 1 | Serial data from the slave or the loader |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Registered chip select, active low |
| buffer | output | 12 | Parallel view of the shift register |
| busy | output | 1 | Transfer in progress, stalls the processor |

## Verification
The hardest situation to create from the ports is a new request, a new `wr_data` value and a raised `init_mode` arriving in the middle of a write that is already running. The stimulus pokes all three for one cycle partway through a transfer. It then checks that the mosi stream, the `busy` length and the buffer still match the original write.

A second delicate case is the extra flush edge of a normal read. It lets `busy` drop only after the staged last bit has landed. The reference model predicts `busy` and `cs_n` on every cycle across write, read and loader transfers, so the model and the design must agree on the flush edge.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} eng_state_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic pkt;
  } xfer_op_t;
endpackage

// File: rtl/spi_eng_rst_sync.sv
module spi_eng_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_req,
  input  logic              read_req,
  input  logic              init_mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cs_n,
  input  logic              flush,
  output logic              busy,
  output logic              load_pend,
  output xfer_op_t          op,
  output logic [DATA_W-1:0] wr_hold,
  output logic              sclk_en
);
  eng_state_e        st_q, st_d;
  logic              ld_q, ld_d;
  xfer_op_t          op_q, op_d;
  logic [DATA_W-1:0] hold_q;
  logic              accept;
  logic              sclk_en_q;

  assign accept = (st_q == ST_IDLE) && (send_req || read_req);

  always_comb begin
    st_d = st_q;
    ld_d = 1'b0;
    op_d = op_q;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d     = ST_BUSY;
          ld_d     = 1'b1;
          op_d.pkt = init_mode;
          op_d.rd  = !init_mode && read_req;
          op_d.wr  = !init_mode && !read_req;
        end
      end
      default: begin
        if (!ld_q && cs_n && !flush) st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ld_q      <= 1'b0;
      op_q      <= '0;
      sclk_en_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      ld_q      <= ld_d;
      op_q      <= op_d;
      sclk_en_q <= !cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (accept) hold_q <= wr_data;
  end

  assign busy      = (st_q == ST_BUSY);
  assign load_pend = ld_q;
  assign op        = op_q;
  assign wr_hold   = hold_q;
  assign sclk_en   = sclk_en_q;

  // R2
  busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cs_n && !flush));

  // R10
  load_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_pend) |-> $past(!busy));
endmodule

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  xfer_op_t                 op,
  input  logic [DATA_W-1:0]        wr_hold,
  input  logic                     miso,
  output logic                     cs_n,
  output logic                     flush,
  output logic [DATA_W+ADDR_W-1:0] shreg
);
  localparam int PW = DATA_W + ADDR_W;
  localparam int CW = $clog2(PW + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] sh_q, sh_d, sh_norm, sh_pkt;
  logic          cs_q, cs_d, fl_q, fl_d, stg_q, stg_d;
  logic          in_bit;

  assign in_bit = op.pkt ? miso : (op.rd ? stg_q : 1'b0);

  for (genvar i = 0; i < PW; i++) begin : g_shift
    if (i == PW - 1) begin : g_top
      assign sh_pkt[i] = in_bit;
    end else begin : g_mid
      assign sh_pkt[i] = sh_q[i+1];
    end
    if (i == DATA_W - 1) begin : g_ins
      assign sh_norm[i] = in_bit;
    end else if (i < DATA_W - 1) begin : g_low
      assign sh_norm[i] = sh_q[i+1];
    end else begin : g_keep
      assign sh_norm[i] = sh_q[i];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    cs_d  = cs_q;
    fl_d  = fl_q;
    stg_d = stg_q;
    if (load) begin
      cnt_d = op.pkt ? CW'(PW) : CW'(DATA_W);
      cs_d  = 1'b0;
      fl_d  = 1'b0;
      if (op.wr) sh_d = {sh_q[PW-1:DATA_W], wr_hold};
    end else if (!cs_q) begin
      if (op.rd) stg_d = miso;
      sh_d  = op.pkt ? sh_pkt : sh_norm;
      cnt_d = cnt_q - CW'(1);
      if (cnt_q == CW'(1)) begin
        cs_d = 1'b1;
        fl_d = op.rd;
      end
    end else if (fl_q) begin
      sh_d = sh_norm;
      fl_d = 1'b0;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      cs_q  <= 1'b1;
      fl_q  <= 1'b0;
      stg_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      cs_q  <= cs_d;
      fl_q  <= fl_d;
      stg_q <= stg_d;
    end
  end

  assign cs_n  = cs_q;
  assign flush = fl_q;
  assign shreg = sh_q;

  // R4
  cnt_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
    cnt_q <= CW'(PW));

  // R4
  cs_close_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!cs_q && !load && cnt_q == CW'(1)) |=> cs_q);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     send_req,
  input  logic                     read_req,
  input  logic                     init_mode,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     miso,
  output logic                     sclk,
  output logic                     mosi,
  output logic                     cs_n,
  output logic [DATA_W+ADDR_W-1:0] buffer,
  output logic                     busy
);
  localparam int PW = DATA_W + ADDR_W;

  logic              rst_int_n;
  logic              load_pend, flush, sclk_en;
  xfer_op_t          op;
  logic [DATA_W-1:0] wr_hold;
  logic [PW-1:0]     shreg;

  spi_eng_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  spi_eng_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .send_req  (send_req),
    .read_req  (read_req),
    .init_mode (init_mode),
    .wr_data   (wr_data),
    .cs_n      (cs_n),
    .flush     (flush),
    .busy      (busy),
    .load_pend (load_pend),
    .op        (op),
    .wr_hold   (wr_hold),
    .sclk_en   (sclk_en)
  );

  spi_eng_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load_pend),
    .op      (op),
    .wr_hold (wr_hold),
    .miso    (miso),
    .cs_n    (cs_n),
    .flush   (flush),
    .shreg   (shreg)
  );

  assign sclk   = sclk_en & ~clk;
  assign mosi   = op.wr & ~cs_n & shreg[0];
  assign buffer = shreg;

  // R6
  mosi_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n |-> !mosi);

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n && $past(cs_n)) |-> !sclk);
endmodule

// File: tb/test_spi_shift_engine.sv
module test_spi_shift_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        send_req = 1'b0, read_req = 1'b0, init_mode = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        miso = 1'b0;
  logic        sclk, mosi, cs_n, busy;
  logic [11:0] buffer;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  spi_shift_engine i_spi_shift_engine (
    .clk(clk), .rst_n(rst_n), .send_req(send_req), .read_req(read_req),
    .init_mode(init_mode), .wr_data(wr_data), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .buffer(buffer), .busy(busy)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural slave: first bit on chip-select fall, next bit after each sclk fall
  logic [11:0] slv_word = 12'h000;
  int slv_idx = 0;
  always @(negedge cs_n) begin
    slv_idx = 0;
    #1 miso = slv_word[0];
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      slv_idx++;
      #1 if (slv_idx < 12) miso = slv_word[slv_idx];
    end
  end

  int sclk_cnt = 0;
  always @(posedge sclk) sclk_cnt++;

  // reference model, compared every cycle
  bit m_run = 1'b0;
  int m_c = 0, m_L = 0, m_bits = 0;
  bit m_wr = 1'b0, m_rd = 1'b0, m_pkt = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic [7:0] rec = 8'h00;
  int nrec = 0;

  always @(posedge clk) begin
    if (m_run) begin
      if (m_c < m_L) m_c++;
      else if (send_req || read_req) begin
        m_c = 0;
        m_pkt = init_mode;
        m_rd = !init_mode && read_req;
        m_wr = !init_mode && !read_req;
        m_L = m_pkt ? 13 : (m_rd ? 10 : 9);
        m_bits = m_pkt ? 12 : 8;
        m_data = wr_data;
        nrec = 0;
      end
    end
    #2;
    if (m_run) begin
      chk(busy === (m_c < m_L), "R2 busy", busy, (m_c < m_L));
      chk(cs_n === !(m_c >= 1 && m_c <= m_bits), "R4 cs_n", cs_n,
          !(m_c >= 1 && m_c <= m_bits));
      if (m_wr && m_c >= 1 && m_c <= m_bits) begin
        if (nrec < 8) rec[nrec] = mosi;
        nrec++;
      end else begin
        chk(mosi === 1'b0, "R6 mosi idle", mosi, 0);
      end
    end
  end

  task automatic xfer(input bit s, input bit r, input bit im, input logic [7:0] d,
                      input logic [11:0] sw, input logic [11:0] exp_buf,
                      input string req, input bit poke);
    @(negedge clk);
    #1;
    send_req = s; read_req = r; init_mode = im; wr_data = d; slv_word = sw;
    sclk_cnt = 0;
    @(posedge clk);
    #1;
    send_req = 0; read_req = 0; init_mode = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      #1;
      read_req = 1; send_req = 1; init_mode = 1; wr_data = 8'h00;
      @(negedge clk);
      #1;
      read_req = 0; send_req = 0; init_mode = 0;
    end
    do begin
      @(posedge clk);
      #1;
    end while (m_c < m_L);
    #3;
    chk(sclk_cnt == m_bits, "R4 sclk edges", sclk_cnt, m_bits);
    if (m_wr) chk(rec === m_data && nrec == 8, "R6 mosi stream", rec, m_data);
    chk(buffer === exp_buf, req, buffer, exp_buf);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk === 1'b0 && mosi === 1'b0, "R1 sclk/mosi", {sclk, mosi}, 0);
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(buffer === 12'h000, "R1 buffer", buffer, 0);
    @(negedge clk);
    #7;
    chk(sclk === 1'b0, "R1 sclk low phase", sclk, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    m_run = 1'b1;

    xfer(1, 0, 0, 8'hA5, 12'h3C3, 12'h000, "R9 write buffer", 0);
    xfer(0, 1, 0, 8'h00, 12'h096, 12'h096, "R7 read buffer", 0);
    xfer(0, 1, 1, 8'h00, 12'hB7E, 12'hB7E, "R8 packet buffer", 0);
    xfer(0, 1, 0, 8'h11, 12'h05A, 12'hB5A, "R7 read keeps upper", 0);
    xfer(1, 0, 0, 8'h3C, 12'hFFF, 12'hB00, "R9 write clears low", 0);
    repeat (6) @(posedge clk);
    #2;
    chk(buffer === 12'hB00, "R11 hold", buffer, 12'hB00);
    xfer(1, 0, 1, 8'h77, 12'h4C3, 12'h4C3, "R3 send with init_mode", 0);
    xfer(1, 1, 0, 8'hFF, 12'h021, 12'h421, "R3 read over send", 0);
    xfer(1, 0, 0, 8'h69, 12'hABC, 12'h400, "R10 poke during write", 1);
    xfer(0, 1, 0, 8'h00, 12'h081, 12'h481, "R7 read edge bits", 0);
    repeat (3) @(posedge clk);
    #2;
    chk(buffer === 12'h481, "R11 hold after read", buffer, 12'h481);
    chk(sclk_cnt == 8, "R5 no sclk while idle", sclk_cnt, 8);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule